// File: doc/BRIEF.md
# Byte-Serial AES Round Sequencer

This block is the control path of a byte-serial AES-128 encryption core. The core has one pipelined S-box and a byte-wide state shift register. The sequencer produces no data. Every cycle it raises a set of strobes that tell the datapath what to do with the byte now in flight: load plaintext and key, add the round key, issue the byte to the S-box, shift the rows, fold a column, step the key schedule, advance the round constant, emit ciphertext, and enable the key registers. A datapath built around these strobes needs no further decoding of its own.

A round has three phases. Sixteen byte cycles come first, then four key-schedule cycles. In the compact build a three-cycle pad follows, which lets the deeper S-box pipeline drain. The position inside a round is held by a 5-bit linear-feedback shift register. It is forced back to its seed when it reaches the state that ends the round. The parameter `INTERLEAVED` selects the build. With it set, rounds last 20 cycles and a new block may begin its first round while the previous block's ciphertext is still leaving. With it cleared, rounds last 23 cycles and blocks never overlap.

Top module: `aes_round_seq`

## Requirements
- R1: While reset is low, and after it is released, the block is idle: `busy_o` is 0, `ready_o` is 1, and every strobe, including `key_en_o`, is 0. A reset in mid-block returns the block to this state.
- R2: A `start_i` seen high while `ready_o` is high starts round 1 in the next cycle. `load_o` is high for exactly the first 16 cycles of round 1 and for no other round.
- R3: In cycle c of every round (c counted from 0), `ark_o` and `sbox_issue_o` are high exactly when c < 16.
- R4: `shiftrows_o` is a single-cycle pulse at c = 15 of every round, and the key-schedule phase follows it directly.
- R5: `keysched_o` is high for c = 16..19 of every round. `rcon_step_o` pulses at c = 19.
- R6: `mix_o` pulses at c = 0, 4, 8 and 12 in rounds 2 to 10 and never in round 1.
- R7: During the key-schedule cycles of round r, `rcon_o` holds the r-th value of 01,02,04,08,10,20,40,80,1B,36 (hex). Each step doubles the value in GF(2^8), reducing by 0x1B. Every accepted start reloads 0x01.
- R8: With `INTERLEAVED`=0 a round lasts 23 cycles. During c = 20..22 `key_en_o` is 0 and no other strobe is raised. At every other busy cycle `key_en_o` is 1.
- R9: After the last cycle of round 10, `out_o` and `key_en_o` are high for 16 cycles. `done_o` pulses on the 16th of these cycles. With `INTERLEAVED`=0 this puts `done_o` in the 246th cycle counted from the first load cycle, and `busy_o` falls in the cycle after.
- R10: With `INTERLEAVED`=1 a round lasts 20 cycles, and `ready_o` is high in the last cycle of round 10. A start taken there loads the next block during the previous block's output cycles, so back-to-back blocks finish 200 cycles apart.
- R11: A start while `ready_o` is low is ignored. The strobe pattern and `done_o` timing of the running block are unchanged.
- R12: With `INTERLEAVED`=0 `ready_o` stays low during output, so loading never overlaps ciphertext output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a block |
| ready_o | output | 1 | A start would be accepted this cycle |
| busy_o | output | 1 | A round or the output phase is running |
| round_o | output | 4 | Current round 1..10, 0 when no round runs |
| load_o | output | 1 | Take plaintext and key bytes |
| ark_o | output | 1 | Add the round-key byte |
| sbox_issue_o | output | 1 | Push the byte into the S-box |
| shiftrows_o | output | 1 | Apply the row shift in the state register |
| mix_o | output | 1 | Start of a column mix step |
| keysched_o | output | 1 | Key-schedule column step |
| rcon_step_o | output | 1 | Advance the round constant |
| rcon_o | output | 8 | Current round constant |
| key_en_o | output | 1 | Clock enable of the key registers |
| out_o | output | 1 | Final key addition and ciphertext byte out |
| done_o | output | 1 | Last ciphertext byte is on the bus |

## Verification
The bench elaborates two copies side by side, one with `INTERLEAVED`=1 and one with `INTERLEAVED`=0, both with ten rounds and 16-byte blocks. Every cycle of each block is compared with a per-cycle reference that depends on the round position. The interleaved copy is what makes the overlap point reachable: a second block is launched exactly in the last cycle of round 10 and its load cycles are checked against the first block's output. The compact copy covers the pad cycles, the 246-cycle latency and a start that arrives during output. Rejected starts, a reset in mid-block and the round-constant reload are driven into both builds.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

  localparam int LFSR_W = 5;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 5'b00001;

  typedef enum logic [1:0] {
    PH_BYTES = 2'd0,
    PH_KEY   = 2'd1,
    PH_PAD   = 2'd2
  } phase_t;

  // One step of the round-position register (period 31 from any nonzero state).
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[3:0], s[4] ^ s[2]};
  endfunction

  // State reached after a number of steps from the seed.
  function automatic logic [LFSR_W-1:0] lfsr_at(input int steps);
    logic [LFSR_W-1:0] s;
    s = LFSR_SEED;
    for (int i = 0; i < steps; i++) s = lfsr_next(s);
    return s;
  endfunction

  // Multiply by x in GF(2^8), reduction polynomial low byte 0x1B.
  function automatic logic [7:0] gf_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

endpackage

// File: rtl/seq_step_ctr.sv
module seq_step_ctr
  import aes_seq_pkg::*;
#(
  parameter int BYTES    = 16,
  parameter int KEYSTEPS = 4,
  parameter int PAD      = 0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   run,
  output phase_t phase_o,
  output logic   byte_last_o,
  output logic   key_last_o,
  output logic   round_end_o,
  output logic   col_start_o
);

  localparam int RLEN = BYTES + KEYSTEPS + PAD;
  localparam int COLS = BYTES / 4;
  localparam logic [LFSR_W-1:0] S_BYTE_LAST = lfsr_at(BYTES - 1);
  localparam logic [LFSR_W-1:0] S_KEY_LAST  = lfsr_at(BYTES + KEYSTEPS - 1);
  localparam logic [LFSR_W-1:0] S_END       = lfsr_at(RLEN - 1);

  logic [LFSR_W-1:0] pos_q;
  phase_t            phase_q;
  logic [COLS-1:0]   col_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= LFSR_SEED;
      phase_q <= PH_BYTES;
    end else if (restart || round_end_o) begin
      pos_q   <= LFSR_SEED;
      phase_q <= PH_BYTES;
    end else if (run) begin
      pos_q <= lfsr_next(pos_q);
      if (byte_last_o)     phase_q <= PH_KEY;
      else if (key_last_o) phase_q <= PH_PAD;
    end
  end

  for (genvar j = 0; j < COLS; j++) begin : g_col
    localparam logic [LFSR_W-1:0] S_COL = lfsr_at(4 * j);
    assign col_hit[j] = (pos_q == S_COL) && (phase_q == PH_BYTES);
  end

  assign phase_o     = phase_q;
  assign byte_last_o = run && (pos_q == S_BYTE_LAST);
  assign key_last_o  = run && (pos_q == S_KEY_LAST);
  assign round_end_o = run && (pos_q == S_END);
  assign col_start_o = run && (|col_hit);

endmodule

// File: rtl/seq_round_ctrl.sv
module seq_round_ctrl
  import aes_seq_pkg::*;
#(
  parameter int NROUNDS = 10,
  localparam int RW     = $clog2(NROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          round_end,
  input  logic          rcon_step,
  output logic          run_o,
  output logic [RW-1:0] round_o,
  output logic          last_round_o,
  output logic [7:0]    rcon_o
);

  localparam logic [RW-1:0] FIRST = RW'(1);
  localparam logic [RW-1:0] LAST  = RW'(NROUNDS);

  logic          run_q;
  logic [RW-1:0] round_q;
  logic [7:0]    rcon_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      round_q <= FIRST;
    end else if (accept) begin
      run_q   <= 1'b1;
      round_q <= FIRST;
    end else if (round_end) begin
      if (round_q == LAST) run_q <= 1'b0;
      else                 round_q <= round_q + FIRST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rcon_q <= 8'h01;
    else if (accept)    rcon_q <= 8'h01;
    else if (rcon_step) rcon_q <= gf_xtime(rcon_q);
  end

  assign run_o        = run_q;
  assign round_o      = run_q ? round_q : '0;
  assign last_round_o = run_q && (round_q == LAST);
  assign rcon_o       = rcon_q;

endmodule

// File: rtl/seq_out_ctrl.sv
module seq_out_ctrl #(
  parameter int BYTES = 16,
  localparam int CW   = $clog2(BYTES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic active_o,
  output logic last_o
);

  localparam logic [CW-1:0] CNT_LAST = CW'(BYTES - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == CNT_LAST) active_q <= 1'b0;
      else                   cnt_q    <= cnt_q + CW'(1);
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q && (cnt_q == CNT_LAST);

endmodule

// File: rtl/aes_round_seq.sv
module aes_round_seq
  import aes_seq_pkg::*;
#(
  parameter bit INTERLEAVED = 1'b1,
  parameter int NROUNDS     = 10,
  parameter int BLOCK_BYTES = 16,
  parameter int KEY_STEPS   = 4,
  parameter int SBOX_EXTRA  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       ready_o,
  output logic       busy_o,
  output logic [3:0] round_o,
  output logic       load_o,
  output logic       ark_o,
  output logic       sbox_issue_o,
  output logic       shiftrows_o,
  output logic       mix_o,
  output logic       keysched_o,
  output logic       rcon_step_o,
  output logic [7:0] rcon_o,
  output logic       key_en_o,
  output logic       out_o,
  output logic       done_o
);

  localparam int PAD = INTERLEAVED ? 0 : SBOX_EXTRA;
  localparam int RW  = $clog2(NROUNDS + 1);

  // Named internal events
  logic          run;
  logic [RW-1:0] round_num;
  logic          last_round;
  phase_t        phase;
  logic          byte_last, key_last, round_end, col_start;
  logic          out_active, out_last;
  logic          idle, overlap_pt, accept, out_go;
  logic          in_bytes, in_key, in_pad;

  assign idle       = !run && !out_active;
  assign overlap_pt = INTERLEAVED && round_end && last_round;
  assign accept     = start_i && (idle || overlap_pt);
  assign out_go     = round_end && last_round;

  seq_step_ctr #(
    .BYTES(BLOCK_BYTES), .KEYSTEPS(KEY_STEPS), .PAD(PAD)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(run),
    .phase_o(phase), .byte_last_o(byte_last), .key_last_o(key_last),
    .round_end_o(round_end), .col_start_o(col_start)
  );

  seq_round_ctrl #(.NROUNDS(NROUNDS)) u_round (
    .clk(clk), .rst_n(rst_n), .accept(accept), .round_end(round_end),
    .rcon_step(rcon_step_o), .run_o(run), .round_o(round_num),
    .last_round_o(last_round), .rcon_o(rcon_o)
  );

  seq_out_ctrl #(.BYTES(BLOCK_BYTES)) u_out (
    .clk(clk), .rst_n(rst_n), .go(out_go),
    .active_o(out_active), .last_o(out_last)
  );

  assign in_bytes = run && (phase == PH_BYTES);
  assign in_key   = run && (phase == PH_KEY);
  assign in_pad   = run && (phase == PH_PAD);

  assign ready_o      = idle || overlap_pt;
  assign busy_o       = !idle;
  assign round_o      = 4'(round_num);
  assign load_o       = in_bytes && (round_num == RW'(1));
  assign ark_o        = in_bytes;
  assign sbox_issue_o = in_bytes;
  assign shiftrows_o  = byte_last;
  assign mix_o        = col_start && (round_num > RW'(1));
  assign keysched_o   = in_key;
  assign rcon_step_o  = key_last;
  assign key_en_o     = (run && !in_pad) || out_active;
  assign out_o        = out_active;
  assign done_o       = out_last;

endmodule

// File: rtl/aes_round_seq_chk.sv
module aes_round_seq_chk
  import aes_seq_pkg::*;
#(
  parameter bit INTERLEAVED = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       ready_o,
  input logic       busy_o,
  input logic [3:0] round_o,
  input logic       load_o,
  input logic       ark_o,
  input logic       sbox_issue_o,
  input logic       shiftrows_o,
  input logic       mix_o,
  input logic       keysched_o,
  input logic       rcon_step_o,
  input logic [7:0] rcon_o,
  input logic       key_en_o,
  input logic       out_o,
  input logic       done_o
);

  // R1: key registers only clocked while busy
  a_r1_keyen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    key_en_o |-> busy_o);

  // R2: a load phase only begins after an accepted start
  a_r2_load_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_o) |-> $past(start_i && ready_o));

  // R3: S-box issue only with a byte in the key-add stage
  a_r3_sbox_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sbox_issue_o |-> (busy_o && round_o != 4'd0));

  // R4: key phase follows the row shift
  a_r4_shift_then_key: assert property (@(posedge clk) disable iff (!rst_n)
    shiftrows_o |=> keysched_o);

  // R5: constant advance is the last key step
  a_r5_step_in_key: assert property (@(posedge clk) disable iff (!rst_n)
    rcon_step_o |-> keysched_o);

  // R6: no column mix in round 1
  a_r6_mix_later: assert property (@(posedge clk) disable iff (!rst_n)
    mix_o |-> (ark_o && int'(round_o) >= 2));

  // R7: constant doubles in GF(2^8) on each step
  a_r7_rcon_double: assert property (@(posedge clk) disable iff (!rst_n)
    (rcon_step_o && !(start_i && ready_o)) |=> (rcon_o == gf_xtime($past(rcon_o))));

  // R7: constant reloaded on start
  a_r7_rcon_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> (rcon_o == 8'h01));

  // R9: done is single cycle and inside the output phase
  a_r9_done_in_out: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> out_o);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: a refused start never opens a load phase
  a_r11_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ready_o) |=> !$rose(load_o));

  if (INTERLEAVED) begin : g_il
    // R10: a start taken while busy overlaps load with output
    a_r10_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ready_o && busy_o) |=> (load_o && out_o));
  end else begin : g_cmp
    // R8: pad cycles raise no work strobe
    a_r8_pad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !key_en_o) |-> !(ark_o || keysched_o || out_o || shiftrows_o));
    // R12: no load during output
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      out_o |-> (!load_o && !ready_o));
  end

endmodule

bind aes_round_seq aes_round_seq_chk #(.INTERLEAVED(INTERLEAVED)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
  .busy_o(busy_o), .round_o(round_o), .load_o(load_o), .ark_o(ark_o),
  .sbox_issue_o(sbox_issue_o), .shiftrows_o(shiftrows_o), .mix_o(mix_o),
  .keysched_o(keysched_o), .rcon_step_o(rcon_step_o), .rcon_o(rcon_o),
  .key_en_o(key_en_o), .out_o(out_o), .done_o(done_o)
);

// File: tb/aes_round_seq_test.sv
`timescale 1ns/1ps
module aes_round_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0;
  logic [9:0] stb0, stb1;   // {load,ark,sbox,shift,mix,key,rstep,key_en,out,done}
  logic [7:0] rc0, rc1;
  logic [3:0] rd0, rd1;
  logic busy0, busy1, ready0, ready1;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // m = 1: interleaved build, m = 0: compact build
  aes_round_seq #(.INTERLEAVED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .ready_o(ready1), .busy_o(busy1),
    .round_o(rd1), .load_o(stb1[9]), .ark_o(stb1[8]), .sbox_issue_o(stb1[7]),
    .shiftrows_o(stb1[6]), .mix_o(stb1[5]), .keysched_o(stb1[4]),
    .rcon_step_o(stb1[3]), .rcon_o(rc1), .key_en_o(stb1[2]), .out_o(stb1[1]),
    .done_o(stb1[0])
  );

  aes_round_seq #(.INTERLEAVED(1'b0)) uut_cmp (
    .clk(clk), .rst_n(rst_n), .start_i(start0), .ready_o(ready0), .busy_o(busy0),
    .round_o(rd0), .load_o(stb0[9]), .ark_o(stb0[8]), .sbox_issue_o(stb0[7]),
    .shiftrows_o(stb0[6]), .mix_o(stb0[5]), .keysched_o(stb0[4]),
    .rcon_step_o(stb0[3]), .rcon_o(rc0), .key_en_o(stb0[2]), .out_o(stb0[1]),
    .done_o(stb0[0])
  );

  // Per-cycle-in-round reference: {byte, shift, colstart, key, rstep, pad}
  localparam logic [5:0] CYC_TBL [23] = '{
    6'b101000, 6'b100000, 6'b100000, 6'b100000,
    6'b101000, 6'b100000, 6'b100000, 6'b100000,
    6'b101000, 6'b100000, 6'b100000, 6'b100000,
    6'b101000, 6'b100000, 6'b100000, 6'b110000,
    6'b000100, 6'b000100, 6'b000100, 6'b000110,
    6'b000001, 6'b000001, 6'b000001
  };
  localparam logic [7:0] RCON_TBL [10] = '{
    8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1B, 8'h36
  };

  function automatic int rlen(input int m);
    return (m == 1) ? 20 : 23;
  endfunction

  // Expected strobes of one block, k cycles after its first load cycle
  function automatic logic [9:0] exp_blk(input int m, input int k);
    logic [9:0] v;
    logic [5:0] row;
    int rl, r;
    v = '0;
    rl = rlen(m);
    if (k < 0) return v;
    if (k < 10 * rl) begin
      r = k / rl + 1;
      row = CYC_TBL[k % rl];
      v[9] = row[5] && (r == 1);
      v[8] = row[5];
      v[7] = row[5];
      v[6] = row[4];
      v[5] = row[3] && (r >= 2);
      v[4] = row[2];
      v[3] = row[1];
      v[2] = !row[0];
    end else if (k < 10 * rl + 16) begin
      v[2] = 1'b1;
      v[1] = 1'b1;
      v[0] = (k == 10 * rl + 15);
    end
    return v;
  endfunction

  function automatic string req_of(input logic [9:0] d);
    if (d[9]) return "R2";
    if (d[8] || d[7]) return "R3";
    if (d[6]) return "R4";
    if (d[5]) return "R6";
    if (d[4] || d[3]) return "R5";
    if (d[2]) return "R8";
    if (d[1] || d[0]) return "R9";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic step_check(input int m, input int ka, input int kb);
    logic [9:0] e, a;
    logic [7:0] rc;
    int rl, kr;
    rl = rlen(m);
    e = exp_blk(m, ka) | exp_blk(m, kb);
    a = (m == 1) ? stb1 : stb0;
    rc = (m == 1) ? rc1 : rc0;
    check(a == e, req_of(a ^ e), $sformatf("strobes m%0d k%0d", m, ka), a, e);
    kr = (ka >= 0 && ka < 10 * rl) ? ka : kb;
    if (e[4] && kr >= 0)  // R7 constant during key steps
      check(rc == RCON_TBL[kr / rl], "R7", $sformatf("rcon m%0d k%0d", m, ka),
            rc, RCON_TBL[kr / rl]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    check(stb0 == 10'd0 && stb1 == 10'd0, "R1", "strobes in reset", {stb1, stb0}, 0);
    check(busy0 == 1'b0 && busy1 == 1'b0, "R1", "busy in reset", {busy1, busy0}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready0 && ready1, "R1", "ready after reset", {ready1, ready0}, 3);
    check(stb0 == 10'd0 && stb1 == 10'd0, "R1", "strobes after reset", {stb1, stb0}, 0);

    // Compact build: one block, refused starts mid-round and during output
    @(negedge clk);
    check(ready0 == 1'b1, "R2", "ready before start", ready0, 1);
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    for (int k = 0; k < 250; k++) begin
      step_check(0, k, -1);
      check(busy0 == (k < 246), "R9", $sformatf("busy k%0d", k), busy0, (k < 246));
      if (k == 245) check(stb0[0] == 1'b1, "R9", "done at 246th cycle", stb0[0], 1);
      if (k == 100) begin
        check(ready0 == 1'b0, "R11", "ready mid-block", ready0, 0);
        start0 = 1'b1;
      end
      if (k == 101) start0 = 1'b0;
      if (k == 238) begin
        check(ready0 == 1'b0, "R12", "ready during output", ready0, 0);
        start0 = 1'b1;
      end
      if (k == 239) start0 = 1'b0;
      @(negedge clk);
    end
    check(ready0 == 1'b1, "R12", "ready after block", ready0, 1);

    // Interleaved build: two blocks back to back, refused starts
    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    for (int k = 0; k < 420; k++) begin
      step_check(1, k, (k >= 200) ? k - 200 : -1);
      if (k == 50) begin
        check(ready1 == 1'b0, "R11", "ready mid-round", ready1, 0);
        start1 = 1'b1;
      end
      if (k == 51) start1 = 1'b0;
      if (k == 199) begin
        check(ready1 == 1'b1, "R10", "ready at overlap point", ready1, 1);
        start1 = 1'b1;
      end
      if (k == 200) start1 = 1'b0;
      if (k == 215) check(stb1[0] == 1'b1, "R10", "first done", stb1[0], 1);
      if (k == 405) begin
        check(ready1 == 1'b0, "R11", "ready during lone output", ready1, 0);
        start1 = 1'b1;
      end
      if (k == 406) start1 = 1'b0;
      if (k == 415) check(stb1[0] == 1'b1, "R10", "second done 200 later", stb1[0], 1);
      @(negedge clk);
    end
    check(busy1 == 1'b0, "R10", "idle after second block", busy1, 0);

    // R1 and R7: reset in mid-block, then a fresh block restarts the constant
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(stb0 == 10'd0 && busy0 == 1'b0, "R1", "mid-block reset", {busy0, stb0}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    for (int k = 0; k < 50; k++) begin
      step_check(0, k, -1);
      @(negedge clk);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule